// File: doc/BRIEF.md
# MDIO Management Command Engine

This block runs clause-22 management transactions toward an Ethernet PHY over a two-wire serial management bus (MDC clock, bidirectional MDIO data). Software controls it through one 32-bit word that is both the command and the status. Writing the word with the go bit set launches a frame built from the opcode, PHY address, register address and, for writes, the data field. The go bit reads back as busy until the frame ends.

When a read frame ends, the returned 16 bits replace the low half of the word. If the PHY did not answer during turnaround, a failure flag is set. Each completed frame gives a one-cycle done pulse; a failed read also gives a one-cycle error pulse. Both go to an interrupt controller. MDC is derived from the system clock by a parameterised divider and toggles only while a frame is running. The data pin is split into output, output-enable and input for an external tri-state pad.

Top module: `mdio_cmd_engine`

## Requirements
- R1: After reset the command word reads 0, MDC and the MDIO output enable are low, and done and error are low.
- R2: Word layout: bit 29 is go/busy, bit 28 is read-fail, bits 27:26 opcode, bits 25:21 PHY address, bits 20:16 register address, bits 15:0 data. Bits 31:30 always read 0. Writing with bit 29 set starts a frame, and bit 29 stays 1 until that frame ends.
- R3: A frame is 64 bits on MDIO, most significant bit first: 32 ones, start pattern 01, the two opcode bits, the 5-bit PHY address, the 5-bit register address, two turnaround bits, then 16 data bits. In a non-read frame the turnaround is driven as 1 then 0 and the data bits come from bits 15:0.
- R4: MDC is high for DIV_HALF system cycles and then low for DIV_HALF cycles. It stays low while the engine is idle. MDIO changes only on an MDC falling edge and is sampled on the rising edge.
- R5: The opcode value 2 (binary 10) selects a read. In a read the engine stops driving MDIO from the first turnaround bit to the end of the frame. The 16 sampled data bits replace bits 15:0 when the frame ends, and bit 28 is cleared if the PHY answered.
- R6: If the second turnaround bit of a read is sampled as 1, bit 28 is set at the end of the frame and error pulses high for one cycle.
- R7: done pulses high for exactly one cycle per frame, in the first cycle in which bit 29 reads 0.
- R8: A command write while busy is ignored. The running frame is unchanged and no fields of the word change.
- R9: A write with bit 29 clear stores opcode, addresses and data without starting a frame. MDC stays idle and no done pulse follows.
- R10: Opcodes other than 2 (0, 1, 3) are sent as driven, write-style frames that carry the given opcode bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_we_i | input | 1 | Write strobe for the command word |
| cmd_wdata_i | input | 32 | Command word to write |
| cmd_rdata_o | output | 32 | Current command/status word |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe_o | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO pad input |
| done_o | output | 1 | Frame complete pulse |
| error_o | output | 1 | Read failure pulse |

## Verification
The assertions check, on every cycle, the rules that hold at any time. The pin is driven only while busy. MDC is idle whenever the engine is not busy. MDIO changes only on MDC falling edges. done coincides with busy being clear, and error never appears without done. A write while busy leaves the fields unchanged, and a new frame opens with the pin driven high. The bench scenarios, run against a PHY model, show the things a per-cycle rule cannot: the full bit order of each frame, the data returned by a read, the fail flag for a PHY that gives no answer, the MDC half-period, and that a command written mid-frame does not alter the frame on the wire.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam int TA_IDX     = 46;   // first turnaround bit
  localparam int DATA_IDX   = 48;   // first data bit
  localparam int BUSY_BIT   = 29;
  localparam int FAIL_BIT   = 28;
  localparam logic [1:0] OP_READ = 2'b10;
  localparam logic [1:0] TA_DRV  = 2'b10;
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int DIV_HALF = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

  logic [CW-1:0] cnt_q;
  logic          mdc_q;
  logic          wrap;

  assign wrap   = run_i && (cnt_q == LAST);
  assign rise_o = wrap && !mdc_q;
  assign fall_o = wrap && mdc_q;
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
  import mdio_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [1:0]  op_i,
  input  logic [4:0]  phy_i,
  input  logic [4:0]  reg_i,
  input  logic [15:0] wdata_i,
  input  logic        rise_i,
  input  logic        fall_i,
  input  logic        mdio_i,
  output logic        active_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  output logic        done_o,
  output logic        fail_o,
  output logic [15:0] rdata_o
);
  localparam int BW = $clog2(FRAME_BITS);
  localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_BITS - 1);
  localparam logic [BW-1:0] TA_BIT   = BW'(TA_IDX);
  localparam logic [BW-1:0] TA2_BIT  = BW'(TA_IDX + 1);
  localparam logic [BW-1:0] DAT_BIT  = BW'(DATA_IDX);

  logic                  active_q;
  logic                  rd_q;
  logic                  ta_bad_q;
  logic [BW-1:0]         bit_q;
  logic [FRAME_BITS-1:0] tx_q;
  logic [15:0]           rx_q;

  assign active_o  = active_q;
  assign mdio_oe_o = active_q && (!rd_q || bit_q < TA_BIT);
  assign mdio_o    = mdio_oe_o && tx_q[FRAME_BITS-1];
  assign done_o    = active_q && fall_i && (bit_q == LAST_BIT);
  assign fail_o    = rd_q && ta_bad_q;
  assign rdata_o   = rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      rd_q     <= 1'b0;
      ta_bad_q <= 1'b0;
      bit_q    <= '0;
      tx_q     <= '0;
      rx_q     <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      rd_q     <= (op_i == OP_READ);
      ta_bad_q <= 1'b0;
      bit_q    <= '0;
      tx_q     <= {32'hFFFF_FFFF, 2'b01, op_i, phy_i, reg_i, TA_DRV, wdata_i};
      rx_q     <= '0;
    end else if (active_q) begin
      if (rise_i && rd_q) begin
        if (bit_q == TA2_BIT) ta_bad_q <= mdio_i;
        if (bit_q >= DAT_BIT) rx_q <= {rx_q[14:0], mdio_i};
      end
      if (fall_i) begin
        if (bit_q == LAST_BIT) begin
          active_q <= 1'b0;
        end else begin
          bit_q <= bit_q + 1'b1;
        end
        tx_q <= {tx_q[FRAME_BITS-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/mdio_cmd_engine.sv
module mdio_cmd_engine
  import mdio_pkg::*;
#(
  parameter int DIV_HALF = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cmd_we_i,
  input  logic [31:0] cmd_wdata_i,
  output logic [31:0] cmd_rdata_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i,
  output logic        done_o,
  output logic        error_o
);
  logic [31:0] cmd_q;
  logic        busy;
  logic        start;
  logic        run;
  logic        rise, fall;
  logic        seq_done, seq_fail;
  logic [15:0] seq_rdata;
  logic        done_q, error_q;

  assign busy        = cmd_q[BUSY_BIT];
  assign start       = cmd_we_i && !busy && cmd_wdata_i[BUSY_BIT];
  assign cmd_rdata_o = cmd_q;
  assign done_o      = done_q;
  assign error_o     = error_q;

  mdio_clkdiv #(.DIV_HALF(DIV_HALF)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .mdc_o  (mdc_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  mdio_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .op_i      (cmd_wdata_i[27:26]),
    .phy_i     (cmd_wdata_i[25:21]),
    .reg_i     (cmd_wdata_i[20:16]),
    .wdata_i   (cmd_wdata_i[15:0]),
    .rise_i    (rise),
    .fall_i    (fall),
    .mdio_i    (mdio_i),
    .active_o  (run),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o),
    .done_o    (seq_done),
    .fail_o    (seq_fail),
    .rdata_o   (seq_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q   <= '0;
      done_q  <= 1'b0;
      error_q <= 1'b0;
    end else begin
      done_q  <= seq_done;
      error_q <= seq_done && seq_fail;
      if (cmd_we_i && !busy) begin
        cmd_q <= {2'b00, cmd_wdata_i[BUSY_BIT], 1'b0, cmd_wdata_i[27:0]};
      end else if (seq_done) begin
        cmd_q[BUSY_BIT] <= 1'b0;
        if (cmd_q[27:26] == OP_READ) begin
          cmd_q[FAIL_BIT] <= seq_fail;
          cmd_q[15:0]     <= seq_rdata;
        end
      end
    end
  end
endmodule

// File: rtl/mdio_cmd_engine_chk.sv
module mdio_cmd_engine_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cmd_we_i,
  input logic [31:0] cmd_wdata_i,
  input logic [31:0] cmd_rdata_o,
  input logic        mdc_o,
  input logic        mdio_o,
  input logic        mdio_oe_o,
  input logic        mdio_i,
  input logic        done_o,
  input logic        error_o
);
  // R5
  oe_only_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mdio_oe_o |-> cmd_rdata_o[29]);

  // R4
  mdc_idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_rdata_o[29] |-> !mdc_o);

  // R4
  mdio_change_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdio_oe_o && $past(mdio_oe_o) && (mdio_o != $past(mdio_o))) |-> $fell(mdc_o));

  // R7
  done_not_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !cmd_rdata_o[29]);

  // R6
  error_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> done_o);

  // R8
  busy_write_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_rdata_o[29] && cmd_we_i) |=> $stable(cmd_rdata_o[27:16]));

  // R3
  frame_opens_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cmd_rdata_o[29]) |-> (mdio_oe_o && mdio_o));

  // R2
  top_bits_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_rdata_o[31:30] == 2'b00);
endmodule

bind mdio_cmd_engine mdio_cmd_engine_chk u_chk (.*);

// File: tb/mdio_cmd_engine_tb.sv
module mdio_cmd_engine_tb;
  localparam int DIV_HALF = 2;
  // {op[1:0], phy[4:0], reg[4:0], data[15:0], respond}
  localparam int NV = 6;
  localparam logic [28:0] VEC [NV] = '{
    {2'b01, 5'h01, 5'h00, 16'hA5C3, 1'b1},
    {2'b10, 5'h1F, 5'h1F, 16'h1234, 1'b1},
    {2'b10, 5'h00, 5'h02, 16'h8001, 1'b0},
    {2'b01, 5'h15, 5'h0A, 16'hFFFF, 1'b1},
    {2'b10, 5'h0A, 5'h15, 16'h0000, 1'b1},
    {2'b11, 5'h03, 5'h1C, 16'h5A5A, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_we = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic [31:0] cmd_rdata;
  logic        mdc, mdio_out, mdio_oe, done, error;
  logic        mdio_line;

  logic        phy_rd = 1'b0;
  logic        phy_resp = 1'b0;
  logic [15:0] phy_data = '0;
  logic        phy_oe = 1'b0;
  logic        phy_val = 1'b0;
  int          phy_cnt = 0;
  logic [63:0] phy_cap = '0;

  int checks = 0;
  int fails = 0;
  int done_cnt = 0;
  int err_cnt = 0;

  always #5 clk = ~clk;

  assign mdio_line = mdio_oe ? mdio_out : (phy_oe ? phy_val : 1'b1);

  mdio_cmd_engine #(.DIV_HALF(DIV_HALF)) u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .cmd_we_i    (cmd_we),
    .cmd_wdata_i (cmd_wdata),
    .cmd_rdata_o (cmd_rdata),
    .mdc_o       (mdc),
    .mdio_o      (mdio_out),
    .mdio_oe_o   (mdio_oe),
    .mdio_i      (mdio_line),
    .done_o      (done),
    .error_o     (error)
  );

  always @(posedge mdc) begin
    phy_cap = {phy_cap[62:0], mdio_line};
    phy_cnt = phy_cnt + 1;
  end

  always @(negedge mdc) begin
    if (phy_rd && phy_resp && phy_cnt >= 47 && phy_cnt <= 63) begin
      phy_oe  = 1'b1;
      phy_val = (phy_cnt == 47) ? 1'b0 : phy_data[63-phy_cnt];
    end else begin
      phy_oe = 1'b0;
    end
  end

  always @(posedge clk) begin
    if (done) done_cnt <= done_cnt + 1;
    if (error) err_cnt <= err_cnt + 1;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_cmd(input logic [31:0] w);
    @(negedge clk);
    cmd_we = 1'b1;
    cmd_wdata = w;
    @(negedge clk);
    cmd_we = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000; i++) begin
      if (!cmd_rdata[29]) break;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [1:0]  op;
    logic [4:0]  pa, ra;
    logic [15:0] dat;
    logic        rsp, isrd;
    logic [63:0] exp_frame;
    int          d0, e0, n;

    repeat (3) @(negedge clk);
    // R1 reset state
    check(cmd_rdata == 32'h0, "R1 word", cmd_rdata, 0);
    check(!mdc && !mdio_oe, "R1 pins", {mdc, mdio_oe}, 0);
    check(!done && !error, "R1 pulses", {done, error}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // table-driven frames: R2 R3 R5 R6 R7 R10
    for (int v = 0; v < NV; v++) begin
      {op, pa, ra, dat, rsp} = VEC[v];
      isrd = (op == 2'b10);
      phy_cnt = 0;
      phy_rd = isrd;
      phy_resp = rsp;
      phy_data = dat;
      d0 = done_cnt;
      e0 = err_cnt;
      write_cmd({2'b11, 1'b1, 1'b1, op, pa, ra, isrd ? ~dat : dat});
      check(cmd_rdata[29] == 1'b1, "R2 busy set", cmd_rdata[29], 1);
      wait_idle();
      @(negedge clk);
      exp_frame = {32'hFFFF_FFFF, 2'b01, op, pa, ra, 2'b10, dat};
      check(!cmd_rdata[29], "R2 busy cleared", cmd_rdata[29], 0);
      check(phy_cnt == 64, "R3 bit count", phy_cnt, 64);
      if (isrd) begin
        check(phy_cap[63:18] == exp_frame[63:18], "R5 read header", phy_cap[63:18], exp_frame[63:18]);
        check(cmd_rdata[28] == !rsp, "R6 fail flag", cmd_rdata[28], !rsp);
        if (rsp) check(cmd_rdata[15:0] == dat, "R5 read data", cmd_rdata[15:0], dat);
        check(err_cnt - e0 == (rsp ? 0 : 1), "R6 error pulse", err_cnt - e0, rsp ? 0 : 1);
      end else begin
        check(phy_cap == exp_frame, op == 2'b01 ? "R3 write frame" : "R10 other opcode frame", phy_cap, exp_frame);
        check(cmd_rdata[28] == 1'b0 && cmd_rdata[15:0] == dat, "R10 word kept", cmd_rdata[28:0], {1'b0, op, pa, ra, dat});
      end
      check(cmd_rdata[27:16] == {op, pa, ra}, "R2 fields", cmd_rdata[27:16], {op, pa, ra});
      check(cmd_rdata[31:30] == 2'b00, "R2 top bits", cmd_rdata[31:30], 0);
      check(done_cnt - d0 == 1, "R7 one done", done_cnt - d0, 1);
    end

    // R4 MDC high time and idle level
    phy_cnt = 0;
    phy_rd = 1'b0;
    write_cmd({4'b0010, 2'b01, 5'h02, 5'h03, 16'h0F0F});
    @(posedge mdc);
    n = 0;
    do begin
      @(posedge clk);
      n++;
      #1;
    end while (mdc);
    check(n == DIV_HALF, "R4 mdc high", n, DIV_HALF);
    n = 0;
    do begin
      @(posedge clk);
      n++;
      #1;
    end while (!mdc);
    check(n == DIV_HALF, "R4 mdc low", n, DIV_HALF);
    wait_idle();
    repeat (10) @(negedge clk);
    check(!mdc, "R4 idle mdc", mdc, 0);

    // R8 write while busy ignored
    phy_cnt = 0;
    phy_rd = 1'b0;
    d0 = done_cnt;
    write_cmd({4'b0010, 2'b01, 5'h11, 5'h05, 16'hC0DE});
    repeat (40) @(negedge clk);
    write_cmd({4'b0010, 2'b10, 5'h07, 5'h09, 16'h1111});
    check(cmd_rdata[27:0] == {2'b01, 5'h11, 5'h05, 16'hC0DE}, "R8 fields held", cmd_rdata[27:0], {2'b01, 5'h11, 5'h05, 16'hC0DE});
    wait_idle();
    repeat (20) @(negedge clk);
    exp_frame = {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h11, 5'h05, 2'b10, 16'hC0DE};
    check(phy_cap == exp_frame && phy_cnt == 64, "R8 frame unchanged", phy_cap, exp_frame);
    check(done_cnt - d0 == 1, "R8 single done", done_cnt - d0, 1);

    // R9 store without start
    phy_cnt = 0;
    d0 = done_cnt;
    write_cmd({4'b1101, 2'b10, 5'h1E, 5'h01, 16'hBEEF});
    repeat (30) @(negedge clk);
    check(cmd_rdata == {4'b0000, 2'b10, 5'h1E, 5'h01, 16'hBEEF}, "R9 stored", cmd_rdata, {4'b0000, 2'b10, 5'h1E, 5'h01, 16'hBEEF});
    check(phy_cnt == 0 && !mdc, "R9 no mdc", phy_cnt, 0);
    check(done_cnt == d0, "R9 no done", done_cnt - d0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule